// File: doc/BRIEF.md
# Clock Doubler Mode Controller

This block sequences an on-chip frequency doubler from a small byte-wide register bus. Software writes a two-bit operating mode. From it the controller derives three registered enables: one that keeps the doubler running, one that runs the lock-up timer, and one that moves the system clock from the oscillator to the doubled clock. A lock-up timer counts oscillator cycles after the doubler is started. A status flag, readable over the bus, tells software when the doubled clock has settled and may be selected.

The controller guards the clock tree against unsafe sequences. Three kinds of request are dropped and latched into a sticky error bit: stopping the doubler directly from doubled-clock operation, changing mode while the chip runs from its slow clock, and asking for the oscillator to stop while the doubler still runs. A second register holds a trim byte for the analog doubler. It is write-only and is presented on an output. The analog doubler, the glitch-free clock switch and the oscillator sit outside this block.

Top module: `dbl_ctrl`

## Requirements
- R1: After a synchronous reset the mode is 00, the timer-length select is 0, the lock flag is 0, all three enables are 0, the oscillator-stop grant is 0, the error bit is 0, `bus_rdata` is 00h and `rev_trim` is 13h.
- R2: The enables follow the mode one cycle after an accepted write to address E8h, with the mode taken from data bits 7:6. The decode of (`dbl_run`, `lock_cnt_run`, `sysclk_sel_dbl`) is: mode 00 gives 0,0,0; mode 01 gives 1,1,0; mode 10 gives 1,0,1; mode 11 gives 1,0,0.
- R3: A read of E8h returns, on the cycle after `bus_rd`, the value {mode[1:0], lock flag, select, 4'b0000}. Reads of any other address return 00h, and `bus_rdata` is 00h in every cycle that follows a cycle without a read.
- R4: An accepted write that moves the mode into 01 from another mode sets the lock flag to 1 and restarts the count. With the select (data bit 4) at 0, the flag returns to 0 exactly 4096 cycles after that write edge and then stays at 0.
- R5: With the select at 1, the flag returns to 0 exactly 1024 cycles after the write edge.
- R6: A write of mode 00 while the mode is 10 is dropped as a whole, including its select bit, and sets the error bit.
- R7: While `slow_mode` is 1, a write that would change the mode is dropped and sets the error bit. A write that keeps the mode is accepted.
- R8: `osc_stop_grant` is 1 in the cycle after `osc_stop_req` is sampled high while `dbl_run` is 0. A request sampled while `dbl_run` is 1 gives no grant and sets the error bit.
- R9: The error bit stays set until `err_clr` is sampled high. If a new violation arrives in the same cycle as the clear, the bit stays set.
- R10: A write to E9h loads `rev_trim` on the next cycle. The register cannot be read back, so a read of E9h returns 00h.
- R11: Writing mode 01 again while already in mode 01 neither restarts the count nor raises the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| slow_mode | input | 1 | Chip is running from its slow clock |
| osc_stop_req | input | 1 | Request to stop the high-frequency oscillator |
| err_clr | input | 1 | Clears the sticky error bit |
| dbl_run | output | 1 | Doubler run enable |
| lock_cnt_run | output | 1 | Lock-up timer run enable |
| sysclk_sel_dbl | output | 1 | 1 selects the doubled clock for the system clock |
| lock_busy | output | 1 | 1 while lock-up has not finished |
| osc_stop_grant | output | 1 | Oscillator may stop |
| seq_err | output | 1 | Sticky error bit for dropped requests |
| rev_trim | output | 8 | Trim byte for the analog doubler |

## Verification
The mode field is driven through every code in a legal sequence: stop, warm-up, doubled, back to the oscillator, stop. This separates a faulty decode of any single enable from a correct one. The lock timer is run with both lengths, and a warm-up write is repeated partway through a count. These cases tell an off-by-one terminal count, a swapped select and a spurious restart apart from correct timing. The illegal-write cases each try one forbidden request alone: doubled straight to stop, a mode change in slow mode, and an oscillator stop while the doubler runs. A violation that coincides with a clear shows whether setting the error bit takes priority over clearing it. A per-cycle reference model compares every output on every clock throughout.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_WARM = 2'b01,
    MODE_DBL  = 2'b10,
    MODE_OSC  = 2'b11
  } dbl_mode_e;

  typedef struct packed {
    dbl_mode_e mode;
    logic      lock_sel;
  } dbl_ctl_s;

  localparam logic [7:0] REV_RESET = 8'h13;

endpackage

// File: rtl/dbl_bus_decode.sv
module dbl_bus_decode #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  CTL_ADDR = 8'hE8,
  parameter logic [7:0]  REV_ADDR = 8'hE9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ctl_wr,
  output logic              rev_wr,
  output logic              ctl_rd
);

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] REV_A = ADDR_W'(REV_ADDR);

  always_comb begin
    ctl_wr = wr && (addr == CTL_A);
    rev_wr = wr && (addr == REV_A);
    ctl_rd = rd && (addr == CTL_A);
  end

endmodule

// File: rtl/dbl_mode_guard.sv
module dbl_mode_guard
  import dbl_pkg::*;
(
  input  dbl_mode_e cur_mode,
  input  dbl_mode_e req_mode,
  input  logic      ctl_wr,
  input  logic      slow_mode,
  input  logic      osc_stop_req,
  input  logic      dbl_running,
  output logic      accept,
  output logic      enter_warm,
  output logic      grant,
  output logic      violation
);

  logic bad_stop;
  logic bad_slow;
  logic bad_osc;

  always_comb begin
    bad_stop   = ctl_wr && (cur_mode == MODE_DBL) && (req_mode == MODE_STOP);
    bad_slow   = ctl_wr && slow_mode && (req_mode != cur_mode);
    bad_osc    = osc_stop_req && dbl_running;
    accept     = ctl_wr && !bad_stop && !bad_slow;
    enter_warm = accept && (req_mode == MODE_WARM) && (cur_mode != MODE_WARM);
    grant      = osc_stop_req && !dbl_running;
    violation  = bad_stop || bad_slow || bad_osc;
  end

endmodule

// File: rtl/dbl_lock_timer.sv
module dbl_lock_timer #(
  parameter int LONG_LOG2  = 12,
  parameter int SHORT_LOG2 = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic short_sel,
  output logic busy
);

  localparam int CNT_W = (LONG_LOG2 > SHORT_LOG2) ? LONG_LOG2 : SHORT_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  generate
    if (LONG_LOG2 == CNT_W) begin : g_long_full
      localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
      localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);
      assign last = short_sel ? SHORT_LAST : LONG_LAST;
    end else begin : g_short_full
      localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((64'd1 << LONG_LOG2) - 64'd1);
      localparam logic [CNT_W-1:0] SHORT_LAST = {CNT_W{1'b1}};
      assign last = short_sel ? SHORT_LAST : LONG_LAST;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (run && busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == last) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbl_ctrl.sv
module dbl_ctrl
  import dbl_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] CTL_ADDR   = 8'hE8,
  parameter logic [7:0] REV_ADDR   = 8'hE9,
  parameter int         LONG_LOG2  = 12,
  parameter int         SHORT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_mode,
  input  logic              osc_stop_req,
  input  logic              err_clr,
  output logic              dbl_run,
  output logic              lock_cnt_run,
  output logic              sysclk_sel_dbl,
  output logic              lock_busy,
  output logic              osc_stop_grant,
  output logic              seq_err,
  output logic [DATA_W-1:0] rev_trim
);

  localparam int MODE_HI = DATA_W - 1;
  localparam int SEL_BIT = DATA_W - 4;

  dbl_ctl_s  ctl_q;
  dbl_mode_e req_mode;
  dbl_mode_e mode_nxt;
  logic ctl_wr, rev_wr, ctl_rd;
  logic accept, enter_warm, grant, violation;

  assign req_mode = dbl_mode_e'(bus_wdata[MODE_HI -: 2]);

  dbl_bus_decode #(
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR),
    .REV_ADDR (REV_ADDR)
  ) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .ctl_wr (ctl_wr),
    .rev_wr (rev_wr),
    .ctl_rd (ctl_rd)
  );

  dbl_mode_guard u_guard (
    .cur_mode     (ctl_q.mode),
    .req_mode     (req_mode),
    .ctl_wr       (ctl_wr),
    .slow_mode    (slow_mode),
    .osc_stop_req (osc_stop_req),
    .dbl_running  (dbl_run),
    .accept       (accept),
    .enter_warm   (enter_warm),
    .grant        (grant),
    .violation    (violation)
  );

  dbl_lock_timer #(
    .LONG_LOG2  (LONG_LOG2),
    .SHORT_LOG2 (SHORT_LOG2)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (enter_warm),
    .run       (ctl_q.mode == MODE_WARM),
    .short_sel (ctl_q.lock_sel),
    .busy      (lock_busy)
  );

  assign mode_nxt = accept ? req_mode : ctl_q.mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q          <= '{mode: MODE_STOP, lock_sel: 1'b0};
      dbl_run        <= 1'b0;
      lock_cnt_run   <= 1'b0;
      sysclk_sel_dbl <= 1'b0;
    end else begin
      if (accept) begin
        ctl_q.mode     <= req_mode;
        ctl_q.lock_sel <= bus_wdata[SEL_BIT];
      end
      dbl_run        <= (mode_nxt != MODE_STOP);
      lock_cnt_run   <= (mode_nxt == MODE_WARM);
      sysclk_sel_dbl <= (mode_nxt == MODE_DBL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_trim <= DATA_W'(REV_RESET);
    end else if (rev_wr) begin
      rev_trim <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_err        <= 1'b0;
      osc_stop_grant <= 1'b0;
    end else begin
      osc_stop_grant <= grant;
      if (violation) begin
        seq_err <= 1'b1;
      end else if (err_clr) begin
        seq_err <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (ctl_rd) begin
      bus_rdata <= {ctl_q.mode, lock_busy, ctl_q.lock_sel, {(DATA_W-4){1'b0}}};
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/dbl_ctrl_chk.sv
module dbl_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic slow_mode,
  input logic osc_stop_req,
  input logic err_clr,
  input logic dbl_run,
  input logic lock_cnt_run,
  input logic sysclk_sel_dbl,
  input logic lock_busy,
  input logic osc_stop_grant,
  input logic seq_err
);

  // R2
  dbl_clk_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    sysclk_sel_dbl |-> (dbl_run && !lock_cnt_run));

  // R6
  no_direct_stop_chk: assert property (@(posedge clk) disable iff (rst)
    sysclk_sel_dbl |=> dbl_run);

  // R7
  slow_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    slow_mode |=> $stable({dbl_run, lock_cnt_run, sysclk_sel_dbl}));

  // R8
  osc_stop_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (osc_stop_req && dbl_run) |=> (!osc_stop_grant && seq_err));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_err && !err_clr) |=> seq_err);

  // R4
  flag_rise_in_warm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_busy) |-> lock_cnt_run);

  // R4
  flag_fall_in_warm_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_busy) |-> lock_cnt_run);

endmodule

bind dbl_ctrl dbl_ctrl_chk u_dbl_ctrl_chk (
  .clk            (clk),
  .rst            (rst),
  .slow_mode      (slow_mode),
  .osc_stop_req   (osc_stop_req),
  .err_clr        (err_clr),
  .dbl_run        (dbl_run),
  .lock_cnt_run   (lock_cnt_run),
  .sysclk_sel_dbl (sysclk_sel_dbl),
  .lock_busy      (lock_busy),
  .osc_stop_grant (osc_stop_grant),
  .seq_err        (seq_err)
);

// File: tb/test_dbl_ctrl.sv
`timescale 1ns/1ps
module test_dbl_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       slow_mode = 1'b0;
  logic       osc_stop_req = 1'b0;
  logic       err_clr = 1'b0;
  logic       dbl_run, lock_cnt_run, sysclk_sel_dbl, lock_busy;
  logic       osc_stop_grant, seq_err;
  logic [7:0] rev_trim;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbl_ctrl i_dbl_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .slow_mode(slow_mode), .osc_stop_req(osc_stop_req), .err_clr(err_clr),
    .dbl_run(dbl_run), .lock_cnt_run(lock_cnt_run),
    .sysclk_sel_dbl(sysclk_sel_dbl), .lock_busy(lock_busy),
    .osc_stop_grant(osc_stop_grant), .seq_err(seq_err), .rev_trim(rev_trim)
  );

  // behavioural reference model
  int m_mode, m_sel, m_busy, m_cnt, m_err, m_grant, m_rev, m_rdata;

  always @(posedge clk) begin
    int om, os, ob, oc, nm, term;
    bit bad;
    if (rst) begin
      m_mode = 0; m_sel = 0; m_busy = 0; m_cnt = 0;
      m_err = 0; m_grant = 0; m_rev = 'h13; m_rdata = 0;
    end else begin
      om = m_mode; os = m_sel; ob = m_busy; oc = m_cnt;
      bad = 0;
      m_rdata = (bus_rd && bus_addr == 8'hE8) ? (om * 64 + ob * 32 + os * 16) : 0;
      if (bus_wr && bus_addr == 8'hE8) begin
        nm = bus_wdata[7:6];
        if ((om == 2 && nm == 0) || (slow_mode && nm != om)) bad = 1;
        else begin
          m_mode = nm; m_sel = bus_wdata[4];
          if (nm == 1 && om != 1) begin m_cnt = 0; m_busy = 1; end
        end
      end
      if (!(m_mode == 1 && om != 1) && om == 1 && ob == 1) begin
        term = os ? 1024 : 4096;
        m_cnt = oc + 1;
        if (m_cnt == term) m_busy = 0;
      end
      if (bus_wr && bus_addr == 8'hE9) m_rev = bus_wdata;
      m_grant = (osc_stop_req && om == 0) ? 1 : 0;
      if (osc_stop_req && om != 0) bad = 1;
      if (bad) m_err = 1;
      else if (err_clr) m_err = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2", "dbl_run", dbl_run, m_mode != 0);
      check("R2", "lock_cnt_run", lock_cnt_run, m_mode == 1);
      check("R2", "sysclk_sel_dbl", sysclk_sel_dbl, m_mode == 2);
      check("R4", "lock_busy", lock_busy, m_busy);
      check("R8", "osc_stop_grant", osc_stop_grant, m_grant);
      check("R9", "seq_err", seq_err, m_err);
      check("R10", "rev_trim", rev_trim, m_rev);
      check("R3", "bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_outs(string req, int r, int l, int s);
    check(req, "dbl_run", dbl_run, r);
    check(req, "lock_cnt_run", lock_cnt_run, l);
    check(req, "sysclk_sel_dbl", sysclk_sel_dbl, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    expect_outs("R1", 0, 0, 0);
    check("R1", "lock_busy", lock_busy, 0);
    check("R1", "seq_err", seq_err, 0);
    check("R1", "osc_stop_grant", osc_stop_grant, 0);
    check("R1", "rev_trim", rev_trim, 'h13);
    check("R1", "bus_rdata", bus_rdata, 0);
    rd(8'hE8, d);
    check("R1", "ctl read", d, 0);

    // R5: warm-up with short lock (mode 01, select 1)
    wr(8'hE8, 8'h50);
    expect_outs("R2", 1, 1, 0);
    check("R4", "flag set", lock_busy, 1);
    repeat (1023) @(negedge clk);
    check("R5", "flag before 1024", lock_busy, 1);
    @(negedge clk);
    check("R5", "flag at 1024", lock_busy, 0);
    rd(8'hE8, d);
    check("R3", "ctl read warm", d, 'h50);

    // R2 doubled clock
    wr(8'hE8, 8'h80);
    expect_outs("R2", 1, 0, 1);
    // R6 direct stop rejected
    wr(8'hE8, 8'h10);
    expect_outs("R6", 1, 0, 1);
    check("R6", "err", seq_err, 1);
    rd(8'hE8, d);
    check("R6", "mode and select kept", d, 'h80);
    // R9 clear
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R9", "err cleared", seq_err, 0);

    // R8 oscillator stop refused while running; R9 set beats clear
    @(negedge clk); osc_stop_req = 1'b1; err_clr = 1'b1;
    @(negedge clk); osc_stop_req = 1'b0; err_clr = 1'b0;
    check("R8", "no grant", osc_stop_grant, 0);
    check("R9", "set wins", seq_err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;

    // legal stop path via mode 11
    wr(8'hE8, 8'hC0);
    expect_outs("R2", 1, 0, 0);
    wr(8'hE8, 8'h00);
    expect_outs("R2", 0, 0, 0);
    check("R6", "no err on legal path", seq_err, 0);

    // R8 grant when doubler off
    @(negedge clk); osc_stop_req = 1'b1;
    @(negedge clk); osc_stop_req = 1'b0;
    check("R8", "grant", osc_stop_grant, 1);
    check("R8", "no err", seq_err, 0);

    // R7 slow mode
    @(negedge clk); slow_mode = 1'b1;
    wr(8'hE8, 8'h40);
    expect_outs("R7", 0, 0, 0);
    check("R7", "err", seq_err, 1);
    wr(8'hE8, 8'h10);
    rd(8'hE8, d);
    check("R7", "same-mode write accepted", d, 'h10);
    @(negedge clk); slow_mode = 1'b0; err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;

    // R10 revision register
    wr(8'hE9, 8'h1B);
    check("R10", "rev_trim", rev_trim, 'h1B);
    rd(8'hE9, d);
    check("R10", "write-only read", d, 0);
    rd(8'h55, d);
    check("R3", "unmapped read", d, 0);

    // R4 long lock and R11 rewrite mid-count
    wr(8'hE8, 8'h40);
    check("R4", "flag set", lock_busy, 1);
    repeat (2000) @(negedge clk);
    wr(8'hE8, 8'h40);
    repeat (4095 - 2002) @(negedge clk);
    check("R11", "flag before 4096", lock_busy, 1);
    @(negedge clk);
    check("R11", "flag at 4096 not restarted", lock_busy, 0);
    repeat (20) @(negedge clk);
    check("R4", "flag stays low", lock_busy, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule